// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a 16-bit down-counter and drives a single output line. The output follows one of six waveforms. A host programs the channel over an 8-bit write bus with a 2-bit address. Address 3 carries control words, and the address equal to the channel's number carries count bytes. Several channels can share one bus because each one accepts only the control words whose select field matches its own number.

The counter advances on the system clock. A gate input can pause counting in the level-controlled waveforms. In the trigger-controlled waveforms, a rising edge on the gate starts or restarts the count instead. A count can be loaded as a single low byte, or as a low byte followed by a high byte. A loaded value of zero means 65536 clocks.

Top module: `ivc_channel`

## Requirements
- R1: After reset the channel is in mode 0 with single-byte loading, its output is low, and it does not count until it is programmed.
- R2: A write at address 3 is a control word for this channel only if bits 7:6 equal the channel number and bit 4 is 1. Bits 5:4 = 01 select low-byte-only loading and 11 select two-byte loading. Bits 3:1 select the mode: 000=0, 001=1, x10=2, x11=3, 100=4, 101=5. Bit 0 is ignored. Any other write at address 3, including select fields for other channels and load fields 00 or 10, has no effect on the channel.
- R3: In two-byte format the first count write is the low byte and the second is the high byte. Counting starts only on the high-byte write. A control word resets the byte order to "low next".
- R4: Mode 0: the output is low from the count write for N gated clocks, then goes high and stays high until the next control word or count write.
- R5: In modes 0, 2, 3 and 4 the count advances only on clocks where the gate is high. A low gate holds both the count and the output.
- R6: Mode 1: the output stays high after the count is written. Each gate rising edge reloads N and drives the output low for N clocks. A rising edge while the output is low restarts the N-clock interval.
- R7: Mode 2: from the count write, the output repeats N-1 clocks high followed by 1 clock low.
- R8: Mode 3: the output repeats (N+1)/2 clocks high followed by N/2 clocks low, using integer division, which gives equal halves for even N.
- R9: Mode 4: from the count write, the output is high for N clocks, low for one clock, then stays high with no repeat.
- R10: Mode 5: writing the count does not start counting, and a gate held high without an edge does not start it either. A gate rising edge starts a high period of N clocks, followed by one low clock.
- R11: A count value of 0 counts 65536 clocks.
- R12: A control word stops any count in progress. It sets the output low for mode 0 and high for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Bus write strobe, one cycle per byte |
| addr | input | 2 | Bus address: 3 = control word, channel number = count byte |
| wrData | input | 8 | Bus write data |
| gate | input | 1 | Gate: level enable or rising-edge trigger, depending on mode |
| cntOut | output | 1 | Counter output waveform |

## Verification
The assertions assume that the gate and bus inputs change synchronously with the clock. They also assume that the rate generator is not given a count of 1 and that a control word and a count write never share a cycle, since the bus carries only one address per cycle. The stimulus drives every input on the falling clock edge and issues one bus write per cycle. Counts are drawn from 2 upward, or set to 0 to reach the 65536 case. The gate is held high during level-mode measurements, except in the directed pause test.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } cntMode_e;

  typedef struct packed {
    logic     cfgWr;    // accepted control word this cycle
    cntMode_e cfgMode;  // mode carried by that control word
    logic     commit;   // full count received this cycle
    logic     trig;     // gate rising edge
    logic     gateLvl;  // gate level
  } chanStrb_t;

endpackage

// File: rtl/ivc_busctl.sv
module ivc_busctl
  import ivc_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int ADDR_W  = 2,
  parameter int CNT_W   = 16,
  parameter int CHAN_ID = 0,
  localparam int EXT_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              gate,
  output cntMode_e          modeSel,
  output chanStrb_t         strb,
  output logic [EXT_W-1:0]  loadVal
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;
  localparam logic [ADDR_W-1:0] CHAN_ADDR = ADDR_W'(CHAN_ID);
  localparam int SEL_HI = BUS_W - 1;
  localparam int SEL_LO = BUS_W - 2;

  cntMode_e         modeReg;
  logic             twoByte;
  logic             hiNext;
  logic [BUS_W-1:0] lowByte;
  logic             gatePrev;
  logic             ctrlHit;
  logic             dataHit;
  logic [CNT_W-1:0] rawCount;

  function automatic cntMode_e decodeMode(input logic [2:0] bits);
    case (bits)
      3'b000:  return M_TERM;
      3'b001:  return M_ONESHOT;
      3'b100:  return M_SWSTROBE;
      3'b101:  return M_HWSTROBE;
      default: return bits[0] ? M_SQUARE : M_RATE;
    endcase
  endfunction

  assign ctrlHit = wrEn && (addr == CTRL_ADDR)
                && (wrData[SEL_HI:SEL_LO] == 2'(CHAN_ID)) && wrData[4];
  assign dataHit = wrEn && (addr == CHAN_ADDR);

  always_comb begin
    if (twoByte) rawCount = CNT_W'({wrData, lowByte});
    else         rawCount = CNT_W'(wrData);
    if (rawCount == '0) loadVal = EXT_W'(1) << CNT_W;
    else                loadVal = {1'b0, rawCount};
  end

  always_comb begin
    strb.cfgWr   = ctrlHit;
    strb.cfgMode = decodeMode(wrData[3:1]);
    strb.commit  = dataHit && (!twoByte || hiNext);
    strb.trig    = gate && !gatePrev;
    strb.gateLvl = gate;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeReg  <= M_TERM;
      twoByte  <= 1'b0;
      hiNext   <= 1'b0;
      lowByte  <= '0;
      gatePrev <= 1'b0;
    end else begin
      gatePrev <= gate;
      if (ctrlHit) begin
        modeReg <= decodeMode(wrData[3:1]);
        twoByte <= wrData[5];
        hiNext  <= 1'b0;
      end else if (dataHit && twoByte) begin
        if (!hiNext) lowByte <= wrData;
        hiNext <= !hiNext;
      end
    end
  end

  assign modeSel = modeReg;

endmodule

// File: rtl/ivc_countpath.sv
module ivc_countpath
  import ivc_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int EXT_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  cntMode_e         modeSel,
  input  chanStrb_t        strb,
  input  logic [EXT_W-1:0] loadVal,
  output logic             cntOut
);

  localparam logic [EXT_W-1:0] ONE = EXT_W'(1);
  localparam logic [EXT_W-1:0] TWO = EXT_W'(2);

  logic [EXT_W-1:0] cnt;
  logic [EXT_W-1:0] reloadVal;
  logic             running;
  logic             armed;
  logic             outReg;
  logic             isGateTrig;
  logic             stepEn;

  function automatic logic [EXT_W-1:0] halfHi(input logic [EXT_W-1:0] v);
    return (v + ONE) >> 1;
  endfunction

  function automatic logic [EXT_W-1:0] halfLo(input logic [EXT_W-1:0] v);
    return v >> 1;
  endfunction

  assign isGateTrig = (modeSel == M_ONESHOT) || (modeSel == M_HWSTROBE);
  assign stepEn     = running && (strb.gateLvl || isGateTrig);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      reloadVal <= '0;
      running   <= 1'b0;
      armed     <= 1'b0;
      outReg    <= 1'b0;
    end else if (strb.cfgWr) begin
      running <= 1'b0;
      armed   <= 1'b0;
      outReg  <= (strb.cfgMode != M_TERM);
    end else if (strb.commit) begin
      reloadVal <= loadVal;
      outReg    <= (modeSel != M_TERM);
      armed     <= isGateTrig;
      running   <= !isGateTrig;
      cnt       <= (modeSel == M_SQUARE) ? halfHi(loadVal) : loadVal;
    end else if (strb.trig && armed && isGateTrig) begin
      cnt     <= reloadVal;
      running <= 1'b1;
      outReg  <= (modeSel == M_HWSTROBE);
    end else if (stepEn) begin
      case (modeSel)
        M_TERM, M_ONESHOT: begin
          if (cnt == ONE) begin
            outReg  <= 1'b1;
            running <= 1'b0;
          end
          cnt <= cnt - ONE;
        end
        M_RATE: begin
          if (cnt == ONE) begin
            outReg <= 1'b1;
            cnt    <= reloadVal;
          end else if (cnt == TWO) begin
            outReg <= 1'b0;
            cnt    <= ONE;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        M_SQUARE: begin
          if (cnt == ONE) begin
            if (outReg) begin
              if (halfLo(reloadVal) == '0) begin
                cnt <= halfHi(reloadVal);
              end else begin
                outReg <= 1'b0;
                cnt    <= halfLo(reloadVal);
              end
            end else begin
              outReg <= 1'b1;
              cnt    <= halfHi(reloadVal);
            end
          end else begin
            cnt <= cnt - ONE;
          end
        end
        M_SWSTROBE, M_HWSTROBE: begin
          if (cnt == ONE) begin
            outReg <= 1'b0;
            cnt    <= '0;
          end else if (cnt == '0) begin
            outReg  <= 1'b1;
            running <= 1'b0;
          end else begin
            cnt <= cnt - ONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign cntOut = outReg;

endmodule

// File: rtl/ivc_channel.sv
module ivc_channel
  import ivc_pkg::*;
#(
  parameter int BUS_W   = 8,
  parameter int ADDR_W  = 2,
  parameter int CNT_W   = 16,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              gate,
  output logic              cntOut
);

  localparam int EXT_W = CNT_W + 1;

  cntMode_e         modeSel;
  chanStrb_t        strb;
  logic [EXT_W-1:0] loadVal;

  ivc_busctl #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CHAN_ID(CHAN_ID)
  ) uBus (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .gate(gate), .modeSel(modeSel), .strb(strb), .loadVal(loadVal)
  );

  ivc_countpath #(.CNT_W(CNT_W)) uPath (
    .clk(clk), .rst(rst), .modeSel(modeSel), .strb(strb),
    .loadVal(loadVal), .cntOut(cntOut)
  );

endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input cntMode_e  modeSel,
  input chanStrb_t strb,
  input logic      gate,
  input logic      cntOut
);

  // R1: output low on the first cycle out of reset
  a_r1_reset_low: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !cntOut);

  // R4: mode 0 output holds high until reprogrammed
  a_r4_term_holds: assert property (@(posedge clk) disable iff (rst)
    (modeSel == M_TERM && cntOut && !strb.cfgWr && !strb.commit) |=> cntOut);

  // R7: rate mode low lasts one gated clock
  a_r7_rate_one_low: assert property (@(posedge clk) disable iff (rst)
    (modeSel == M_RATE && !cntOut && gate) |=> cntOut);

  // R9 and R10: strobe modes low for one clock only
  a_r9_strobe_one_low: assert property (@(posedge clk) disable iff (rst)
    (((modeSel == M_SWSTROBE) && gate) || (modeSel == M_HWSTROBE)) && !cntOut
    |=> cntOut);

  // R12: control word sets the initial output level of its mode
  a_r12_cfg_level: assert property (@(posedge clk) disable iff (rst)
    strb.cfgWr |=> (cntOut == (modeSel != M_TERM)));

endmodule

bind ivc_channel ivc_checker uChk (
  .clk(clk), .rst(rst), .modeSel(modeSel), .strb(strb),
  .gate(gate), .cntOut(cntOut)
);

// File: tb/tb_ivc_channel.sv
`timescale 1ns/1ps
module tb_ivc_channel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       gate = 1'b0;
  logic       gate0 = 1'b0;
  logic       dOut;
  logic       dOut0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ivc_channel #(.CHAN_ID(2)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .gate(gate), .cntOut(dOut)
  );

  ivc_channel #(.CHAN_ID(0)) dutC0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .gate(gate0), .cntOut(dOut0)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ctrlWord(input int mode, input bit two);
    busWrite(2'd3, {2'b10, two ? 2'b11 : 2'b01, 3'(mode), 1'b0});
  endtask

  task automatic loadCount(input int n, input bit two);
    busWrite(2'd2, 8'(n));
    if (two) busWrite(2'd2, 8'(n >> 8));
  endtask

  task automatic runLen(input logic lvl, input int limit, output int len);
    len = 0;
    while (dOut == lvl && len < limit) begin
      len++;
      @(negedge clk);
    end
  endtask

  function automatic int sqHi(input int n); return (n + 1) / 2; endfunction
  function automatic int sqLo(input int n); return n / 2; endfunction

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len;
    int tot;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state, no counting
    runLen(1'b0, 20, len);
    chk("R1 reset low", len, 20);

    // R3 + R4: two-byte load of 300 in mode 0
    gate = 1'b1;
    ctrlWord(0, 1'b1);
    busWrite(2'd2, 8'h2C);
    runLen(1'b0, 100, len);
    chk("R3 no start after low byte", len, 100);
    busWrite(2'd2, 8'h01);
    runLen(1'b0, 70000, len);
    chk("R4 mode0 low length", len, 300);
    runLen(1'b1, 50, len);
    chk("R4 mode0 stays high", len, 50);

    // R7 + R12: rate generator N=7
    ctrlWord(2, 1'b0);
    chk("R12 level after mode2 word", int'(dOut), 1);
    loadCount(7, 1'b0);
    runLen(1'b1, 1000, len);
    chk("R7 high part", len, 6);
    runLen(1'b0, 1000, len);
    chk("R7 low part", len, 1);
    runLen(1'b1, 1000, len);
    chk("R7 second period high", len, 6);

    // R2: ignored control words (other channel, format 00, format 10)
    busWrite(2'd3, 8'h50);
    busWrite(2'd3, 8'h80);
    busWrite(2'd3, 8'hA0);
    runLen(1'b1, 100, len);
    runLen(1'b0, 100, len);
    chk("R2 ignored words, low part", len, 1);
    runLen(1'b1, 100, len);
    chk("R2 ignored words, high part", len, 6);

    // R12: mode 0 word stops counting and drives low
    ctrlWord(0, 1'b0);
    runLen(1'b0, 50, len);
    chk("R12 mode0 word low and stopped", len, 50);

    // R2 + R8: mode bits 111 alias square wave, bit0 ignored, odd N=9
    busWrite(2'd3, 8'h9F);
    loadCount(9, 1'b0);
    runLen(1'b1, 1000, len);
    chk("R8 odd high", len, 5);
    runLen(1'b0, 1000, len);
    chk("R8 odd low", len, 4);

    // R8: even N=10
    ctrlWord(3, 1'b0);
    loadCount(10, 1'b0);
    runLen(1'b1, 1000, len);
    chk("R8 even high", len, 5);
    runLen(1'b0, 1000, len);
    chk("R8 even low", len, 5);
    runLen(1'b1, 1000, len);
    chk("R8 even high again", len, 5);

    // R9: software strobe N=5, no repeat
    ctrlWord(4, 1'b0);
    loadCount(5, 1'b0);
    runLen(1'b1, 1000, len);
    chk("R9 high before strobe", len, 5);
    runLen(1'b0, 1000, len);
    chk("R9 strobe width", len, 1);
    runLen(1'b1, 100, len);
    chk("R9 no repeat", len, 100);

    // R5: gate pause of 30 clocks in mode 4, N=20
    ctrlWord(4, 1'b0);
    loadCount(20, 1'b0);
    repeat (5) @(negedge clk);
    gate = 1'b0;
    repeat (30) @(negedge clk);
    gate = 1'b1;
    runLen(1'b1, 1000, len);
    chk("R5 paused high length", 35 + len, 50);
    runLen(1'b0, 1000, len);
    chk("R5 strobe after pause", len, 1);

    // R6: gate-triggered one-shot N=8 with retrigger
    gate = 1'b0;
    ctrlWord(1, 1'b0);
    loadCount(8, 1'b0);
    runLen(1'b1, 20, len);
    chk("R6 high while untriggered", len, 20);
    gate = 1'b1;
    @(negedge clk);
    runLen(1'b0, 1000, len);
    chk("R6 low width", len, 8);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    repeat (2) @(negedge clk);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk("R6 low at retrigger", int'(dOut), 0);
    runLen(1'b0, 1000, len);
    chk("R6 retrigger extends low", 4 + len, 12);

    // R10: gate-triggered strobe N=6, level alone does not start it
    ctrlWord(5, 1'b0);
    loadCount(6, 1'b0);
    runLen(1'b1, 30, len);
    chk("R10 no start on level", len, 30);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    runLen(1'b1, 1000, len);
    chk("R10 high after edge", len, 6);
    runLen(1'b0, 1000, len);
    chk("R10 strobe width", len, 1);
    runLen(1'b1, 40, len);
    chk("R10 no repeat", len, 40);

    // R11: count 0 means 65536
    ctrlWord(4, 1'b0);
    loadCount(0, 1'b0);
    runLen(1'b1, 70000, len);
    chk("R11 zero count length", len, 65536);
    runLen(1'b0, 1000, len);
    chk("R11 strobe after full count", len, 1);

    // Random mix of level-gated modes (R4 R7 R8 R9, R2 aliases, R3 loads)
    for (int it = 0; it < 40; it++) begin
      int mb;
      int em;
      int n;
      bit two;
      mb = $urandom_range(0, 7);
      if (mb == 1 || mb == 5) mb = 4;
      em = (mb == 6) ? 2 : (mb == 7) ? 3 : mb;
      n = $urandom_range(2, 60);
      if ($urandom_range(0, 3) == 0) n = n + 256;
      two = (n > 255) ? 1'b1 : 1'($urandom_range(0, 1));
      busWrite(2'd3, {2'b10, two ? 2'b11 : 2'b01, 3'(mb), 1'($urandom_range(0, 1))});
      loadCount(n, two);
      case (em)
        0: begin
          runLen(1'b0, 2000, len); chk("R4 random low", len, n);
        end
        2: begin
          runLen(1'b1, 2000, len); chk("R7 random high", len, n - 1);
          runLen(1'b0, 2000, len); chk("R7 random low", len, 1);
        end
        3: begin
          runLen(1'b1, 2000, len); chk("R8 random high", len, sqHi(n));
          runLen(1'b0, 2000, len); chk("R8 random low", len, sqLo(n));
        end
        default: begin
          runLen(1'b1, 2000, len); tot = len;
          chk("R9 random high", tot, n);
          runLen(1'b0, 2000, len); chk("R9 random strobe", len, 1);
        end
      endcase
    end

    // R2: channel 0 never selected, stays in reset state
    chk("R2 other channel untouched", int'(dOut0), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule